// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received Ethernet frames from a byte stream and stores them in memory buffers. The buffers are described by a circular ring of two-word descriptors in the same memory. When a frame starts, the block reads the current descriptor's address word. If the descriptor is free, the block packs the incoming bytes into 32-bit words and writes them to the buffer that word names. When the frame ends or the buffer fills, it writes the status word and then hands the descriptor back by setting its ownership bit. It then moves to the next descriptor, or back to the ring base where a descriptor carries the wrap mark.

A frame longer than one buffer carries on into the following descriptor. Only the final buffer carries the end mark and the frame length. If the descriptor due next is still owned by software, the block raises a one-cycle no-buffer pulse and discards the rest of the frame. The ring pointer then stays on that descriptor, so the next frame tries it again. Reception is gated by an enable input; while it is low and the block is idle, the pointer returns to the ring base.

The memory port is one word wide and makes a single access per cycle. Read data is returned on the cycle after the request.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset the memory port is idle (mem_req low), nobuf_pulse is low, and rx_ready is high while no frame start is offered.
- R2: A descriptor occupies two words: the address word at the ring pointer P and the status word at P+4. Bits 31:2 of the address word, with bits 1:0 cleared, give the byte address of the buffer.
- R3: Frame bytes are written as whole 32-bit words to consecutive word addresses from the buffer address. The first byte of each word goes in bits 7:0, the next in 15:8, and so on. Unused upper lanes of a final partial word are zero.
- R4: After filling a buffer, the block writes the status word and then, on the next cycle, the address word at P with bit 0 set and all other bits unchanged.
- R5: The status word has bit 14 set only in the frame's first buffer. Bit 15 and the total frame byte count in bits 13:0 appear only in the frame's last buffer. All other bits are zero, so a middle buffer's status is 0.
- R6: One buffer holds BUF_UNITS*UNIT_BYTES bytes (default 24*64 = 1536). A longer frame continues into the next descriptor.
- R7: After a hand-back the pointer moves to P+8, or to the ring base if bit 1 of the address word was set.
- R8: If the fetched address word has bit 0 set, nobuf_pulse is high for one cycle. The rest of the frame is consumed with no memory write, and the pointer does not move.
- R9: While rx_on is low no frame is stored and all bytes are consumed. While the block is idle and rx_on is low, the pointer returns to ring_base. Bytes that arrive while idle without rx_first set are also consumed and discarded.
- R10: rx_ready is low while a descriptor read is in flight and during the status and ownership writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base | input | 32 | Byte address of the first descriptor (8-byte aligned) |
| rx_on | input | 1 | Receive enable |
| rx_data | input | 8 | Frame byte |
| rx_valid | input | 1 | rx_data holds a byte |
| rx_first | input | 1 | Byte is the first of a frame |
| rx_last | input | 1 | Byte is the last of a frame |
| rx_ready | output | 1 | Byte is taken on this clock edge when rx_valid is high |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| nobuf_pulse | output | 1 | Descriptor was still owned; frame dropped |

## Verification
Timing from the frame's first byte:
- The descriptor read is issued one cycle after the first byte is presented, and nobuf_pulse is due the cycle after that read.
- Each data word is written in the same cycle that the byte completing it is accepted.
- The status write follows the buffer's final byte by one cycle, and the ownership write comes one cycle after the status write.

The scoreboard checks all memory writes in the order they are issued, comparing each at the falling edge of the cycle in which it is requested. Each frame is followed by a settling gap before the queue and the no-buffer count are checked, so the checks do not depend on the exact cycle.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  localparam int OWN_BIT  = 0;
  localparam int WRAP_BIT = 1;
  localparam int LEN_W    = 14;
  localparam int SOF_BIT  = 14;
  localparam int EOF_BIT  = 15;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_FWAIT, ST_FILL, ST_WSTAT, ST_WOWN, ST_DROP
  } rxr_state_e;

  // status word for a buffer: start mark, end mark, length only on the end buffer
  function automatic logic [31:0] status_word(input logic sof, input logic eof,
                                              input logic [LEN_W-1:0] len);
    logic [31:0] w;
    w = '0;
    w[SOF_BIT] = sof;
    if (eof) begin
      w[EOF_BIT]     = 1'b1;
      w[LEN_W-1:0]   = len;
    end
    return w;
  endfunction

  function automatic logic [31:0] ring_next(input logic [31:0] cur, input logic [31:0] base,
                                            input logic wrap);
    return wrap ? base : cur + 32'd8;
  endfunction

  function automatic logic [31:0] buf_addr(input logic [31:0] dsc);
    return {dsc[31:2], 2'b00};
  endfunction

  function automatic logic [31:0] lane_put(input logic [31:0] w, input logic [7:0] b,
                                           input logic [1:0] lane);
    logic [31:0] r;
    r = w;
    case (lane)
      2'd0: r[7:0]   = b;
      2'd1: r[15:8]  = b;
      2'd2: r[23:16] = b;
      default: r[31:24] = b;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rxr_packer.sv
module rxr_packer
  import rxr_pkg::*;
#(
  parameter int BUF_BYTES = 1536
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_frame,
  input  logic             clr_buf,
  input  logic             take,
  input  logic [7:0]       din,
  input  logic             din_last,
  output logic             flush,
  output logic [31:0]      word,
  output logic [31:0]      offset,
  output logic             buf_last,
  output logic [LEN_W-1:0] frm_len
);
  localparam int CNT_W = $clog2(BUF_BYTES + 1);

  logic [CNT_W-1:0] cnt;
  logic [31:0]      hold;
  logic [1:0]       lane;

  assign lane     = cnt[1:0];
  assign word     = lane_put(hold, din, lane);
  assign buf_last = (cnt == CNT_W'(BUF_BYTES - 1));
  assign flush    = take && ((lane == 2'd3) || din_last || buf_last);
  assign offset   = 32'(cnt) & ~32'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      hold <= '0;
    end else if (clr_buf) begin
      cnt  <= '0;
      hold <= '0;
    end else if (take) begin
      cnt  <= cnt + 1'b1;
      hold <= flush ? 32'd0 : word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         frm_len <= '0;
    else if (clr_frame) frm_len <= '0;
    else if (take)      frm_len <= frm_len + 1'b1;
  end

endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr
  import rxr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] base,
  input  logic        load_base,
  input  logic        step,
  input  logic        wrap,
  output logic [31:0] ptr
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      armed <= 1'b0;
    end else if (load_base || !armed) begin
      ptr   <= base;
      armed <= 1'b1;
    end else if (step) begin
      ptr   <= ring_next(ptr, base, wrap);
    end
  end

endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
  import rxr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_on,
  input  logic        rx_valid,
  input  logic        rx_first,
  input  logic        rx_last,
  input  logic [31:0] rd_data,
  input  logic        buf_last,
  output logic        rx_ready,
  output logic        take,
  output logic        clr_frame,
  output logic        clr_buf,
  output logic        ev_fetch,
  output logic        ev_stat,
  output logic        ev_own,
  output logic        ev_nobuf,
  output logic        base_hold,
  output logic [31:0] dsc,
  output logic        sof_pend,
  output logic        eof_flag
);
  rxr_state_e state, nxt;
  logic       buf_done;

  assign buf_done = take && (rx_last || buf_last);

  always_comb begin
    nxt       = state;
    rx_ready  = 1'b0;
    take      = 1'b0;
    clr_frame = 1'b0;
    clr_buf   = 1'b0;
    ev_fetch  = 1'b0;
    ev_stat   = 1'b0;
    ev_own    = 1'b0;
    ev_nobuf  = 1'b0;
    base_hold = 1'b0;
    case (state)
      ST_IDLE: begin
        base_hold = !rx_on;
        if (rx_on && rx_valid && rx_first) begin
          nxt       = ST_FETCH;
          clr_frame = 1'b1;
        end else begin
          rx_ready  = 1'b1;
        end
      end
      ST_FETCH: begin
        ev_fetch = 1'b1;
        clr_buf  = 1'b1;
        nxt      = ST_FWAIT;
      end
      ST_FWAIT: begin
        if (rd_data[OWN_BIT]) begin
          ev_nobuf = 1'b1;
          nxt      = ST_DROP;
        end else begin
          nxt      = ST_FILL;
        end
      end
      ST_FILL: begin
        rx_ready = 1'b1;
        take     = rx_valid;
        if (buf_done) nxt = ST_WSTAT;
      end
      ST_WSTAT: begin
        ev_stat = 1'b1;
        nxt     = ST_WOWN;
      end
      ST_WOWN: begin
        ev_own = 1'b1;
        nxt    = eof_flag ? ST_IDLE : ST_FETCH;
      end
      ST_DROP: begin
        rx_ready = 1'b1;
        if (rx_valid && rx_last) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      dsc      <= '0;
      sof_pend <= 1'b0;
      eof_flag <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_FWAIT) dsc <= rd_data;
      if (clr_frame)         sof_pend <= 1'b1;
      else if (ev_own)       sof_pend <= 1'b0;
      if (buf_done)          eof_flag <= rx_last;
    end
  end

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int BUF_UNITS  = 24,
  parameter int UNIT_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ring_base,
  input  logic        rx_on,
  input  logic [7:0]  rx_data,
  input  logic        rx_valid,
  input  logic        rx_first,
  input  logic        rx_last,
  output logic        rx_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        nobuf_pulse
);
  localparam int BUF_BYTES = BUF_UNITS * UNIT_BYTES;

  // named internal events, also watched by the bound checker
  logic             ev_fetch, ev_stat, ev_own, ev_nobuf, ev_wdata;
  logic             take, clr_frame, clr_buf, base_hold, buf_last;
  logic             sof_pend, eof_flag;
  logic [31:0]      dsc, ptr, buf_base, pk_word, pk_off;
  logic [LEN_W-1:0] frm_len;
  wire  [31:0]      buf_lim = 32'(BUF_BYTES);

  rxr_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_on     (rx_on),
    .rx_valid  (rx_valid),
    .rx_first  (rx_first),
    .rx_last   (rx_last),
    .rd_data   (mem_rdata),
    .buf_last  (buf_last),
    .rx_ready  (rx_ready),
    .take      (take),
    .clr_frame (clr_frame),
    .clr_buf   (clr_buf),
    .ev_fetch  (ev_fetch),
    .ev_stat   (ev_stat),
    .ev_own    (ev_own),
    .ev_nobuf  (ev_nobuf),
    .base_hold (base_hold),
    .dsc       (dsc),
    .sof_pend  (sof_pend),
    .eof_flag  (eof_flag)
  );

  rxr_packer #(.BUF_BYTES(BUF_BYTES)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_frame (clr_frame),
    .clr_buf   (clr_buf),
    .take      (take),
    .din       (rx_data),
    .din_last  (rx_last),
    .flush     (ev_wdata),
    .word      (pk_word),
    .offset    (pk_off),
    .buf_last  (buf_last),
    .frm_len   (frm_len)
  );

  rxr_ring_ptr u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .base      (ring_base),
    .load_base (base_hold),
    .step      (ev_own),
    .wrap      (dsc[WRAP_BIT]),
    .ptr       (ptr)
  );

  assign buf_base    = buf_addr(dsc);
  assign nobuf_pulse = ev_nobuf;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    if (ev_fetch) begin
      mem_req   = 1'b1;
      mem_addr  = ptr;
    end else if (ev_wdata) begin
      mem_req   = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = buf_base + pk_off;
      mem_wdata = pk_word;
    end else if (ev_stat) begin
      mem_req   = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = ptr + 32'd4;
      mem_wdata = status_word(sof_pend, eof_flag, frm_len);
    end else if (ev_own) begin
      mem_req   = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = ptr;
      mem_wdata = dsc | 32'd1;
    end
  end

endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_ready,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        ev_fetch,
  input logic        ev_wdata,
  input logic        ev_stat,
  input logic        ev_own,
  input logic        ev_nobuf,
  input logic [31:0] buf_base,
  input logic [31:0] buf_lim
);
  AST_OWN_AFTER_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stat |=> (ev_own && mem_we && mem_wdata[0]));                      // R4
  AST_DESC_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_own |-> (mem_addr == $past(mem_addr) - 32'd4));                     // R2
  AST_NOBUF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nobuf |=> (!mem_req && rx_ready));                                  // R8
  AST_READ_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> !rx_ready);                                   // R10
  AST_WB_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stat || ev_own) |-> !rx_ready);                                    // R10
  AST_IN_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wdata |-> ((mem_addr - buf_base) < buf_lim));                       // R6
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_fetch, ev_wdata, ev_stat, ev_own}));                      // R2
endmodule

bind rx_ring_writer rx_ring_writer_chk u_chk (.*);

// File: tb/rx_ring_writer_test.sv
module rx_ring_writer_test;
  localparam int BUFB = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ring_base = 32'h100;
  logic        rx_on = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0, rx_first = 1'b0, rx_last = 1'b0;
  logic        rx_ready, mem_req, mem_we, nobuf_pulse;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  always #2 clk = ~clk;

  rx_ring_writer #(.BUF_UNITS(1), .UNIT_BYTES(BUFB)) uut (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .rx_on(rx_on),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_first(rx_first), .rx_last(rx_last),
    .rx_ready(rx_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .nobuf_pulse(nobuf_pulse)
  );

  logic [31:0] mem [0:1023];
  always @(posedge clk) begin
    if (mem_req && mem_we)  mem[mem_addr[11:2]] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[11:2]];
  end

  int checks = 0, errors = 0, nobuf_seen = 0, m_nobuf = 0, m_idx = 0;
  bit done = 1'b0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] m_desc [3] = '{32'h100, 32'h108, 32'h110};
  logic [31:0] m_bufa [3] = '{32'h200, 32'h240, 32'h280};
  logic [31:0] m_dword[3] = '{32'h200, 32'h240, 32'h282};
  bit          m_own  [3] = '{1'b0, 1'b0, 1'b0};

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fb(input int seed, input int i);
    return 8'(seed * 17 + i * 5 + 1);
  endfunction

  task automatic push(input logic [31:0] a, input logic [31:0] d, input string tag);
    exp_q.push_back({a, d});
    tag_q.push_back(tag);
  endtask

  // scoreboard model of the ring: pushes expected writes in issue order
  task automatic push_frame(input int len, input int seed);
    int idx, pos, chunk;
    bit first;
    logic [31:0] d, st;
    idx = m_idx; pos = 0; first = 1'b1;
    while (pos < len) begin
      if (m_own[idx]) begin
        m_nobuf++;                                    // R8 drop, pointer stays
        break;
      end
      chunk = (len - pos > BUFB) ? BUFB : len - pos;  // R6 continuation
      for (int w = 0; w < (chunk + 3) / 4; w++) begin
        d = '0;
        for (int l = 0; l < 4; l++)
          if (4 * w + l < chunk) d[8*l +: 8] = fb(seed, pos + 4 * w + l);
        push(m_bufa[idx] + 32'(4 * w), d, "R3");
      end
      pos += chunk;
      st = first ? 32'h4000 : 32'h0;
      if (pos >= len) st = st | 32'h8000 | 32'(len);
      push(m_desc[idx] + 32'd4, st, "R5 R6");
      push(m_desc[idx], m_dword[idx] | 32'd1, "R4 R7");
      m_own[idx] = 1'b1;
      first = 1'b0;
      idx = (idx + 1) % 3;
    end
    m_idx = idx;
  endtask

  task automatic send_frame(input int len, input int seed, input bit with_first);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = fb(seed, i);
      rx_first = with_first && (i == 0);
      rx_last  = (i == len - 1);
      #1;
      while (!rx_ready) begin
        @(negedge clk);
        #1;
      end
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_first = 1'b0; rx_last = 1'b0;
  endtask

  task automatic settle(input string req);
    repeat (12) @(negedge clk);
    chk(exp_q.size() == 0, req, 64'(exp_q.size()), 64'd0);
    chk(nobuf_seen == m_nobuf, "R8", 64'(nobuf_seen), 64'(m_nobuf));
  endtask

  task automatic free_all;
    for (int i = 0; i < 3; i++) begin
      mem[m_desc[i][11:2]] = m_dword[i];
      m_own[i] = 1'b0;
    end
  endtask

  // monitor: compares every memory write against the queue head
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (mem_req && mem_we) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected write", {mem_addr, mem_wdata}, 64'd0);
        end else begin
          logic [63:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({mem_addr, mem_wdata} == e, t, {mem_addr, mem_wdata}, e);
        end
      end
      if (mem_req && !mem_we) chk(!rx_ready, "R10", 64'(rx_ready), 64'd0);
      if (nobuf_pulse) nobuf_seen++;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    free_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(mem_req == 1'b0, "R1", 64'(mem_req), 64'd0);
    chk(nobuf_pulse == 1'b0, "R1", 64'(nobuf_pulse), 64'd0);
    chk(rx_ready == 1'b1, "R1", 64'(rx_ready), 64'd1);

    // R9: disabled, frame consumed, nothing stored
    send_frame(5, 1, 1'b1);
    settle("R9");
    chk(mem[32'h100 >> 2] == 32'h200, "R9", 64'(mem[32'h100 >> 2]), 64'h200);

    rx_on = 1'b1;
    // R9: bytes without a start mark while idle are discarded
    send_frame(3, 2, 1'b0);
    settle("R9");

    push_frame(6, 3);  send_frame(6, 3, 1'b1);  settle("R3");   // single buffer, partial word
    push_frame(16, 4); send_frame(16, 4, 1'b1); settle("R6");   // exactly one buffer
    push_frame(20, 5); send_frame(20, 5, 1'b1); settle("R8");   // wraps to owned d0 (R7)
    push_frame(5, 6);  send_frame(5, 6, 1'b1);  settle("R8");   // still owned, retried

    free_all();
    push_frame(20, 7); send_frame(20, 7, 1'b1); settle("R6");   // d0 then d1
    free_all();
    push_frame(33, 8); send_frame(33, 8, 1'b1); settle("R5");   // d2 first, d0 middle, d1 last
    chk(mem[32'h10C >> 2] == 32'h8021, "R5", 64'(mem[32'h10C >> 2]), 64'h8021);
    chk(mem[32'h104 >> 2] == 32'h0, "R5", 64'(mem[32'h104 >> 2]), 64'h0);

    // R9: disabling while idle returns the pointer to ring_base
    @(negedge clk); rx_on = 1'b0;
    repeat (2) @(negedge clk); rx_on = 1'b1;
    m_idx = 0;
    free_all();
    push_frame(3, 9); send_frame(3, 9, 1'b1); settle("R9");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule